// File: doc/BRIEF.md
# Bus Address Decoder with Boot Overlay

This block sits between a 24-bit, big-endian processor bus and the memories and peripherals behind it. For each strobed access it takes an address, a size code and a read/write flag. One clock later it returns one of three results: a single select for RAM, ROM or one of ten peripheral windows; or a bus-error pulse. With a select it also returns an offset local to the selected target and a four-lane byte mask on a 32-bit data path.

After reset a boot overlay is armed. While it is armed, only the two long-word reads at addresses 0 and 4 are legal. These two reads are steered to ROM so that the processor can fetch its initial stack pointer and program counter from there. The overlay drops after the read at address 4. Two RAM windows, one read-only and one read-write, are set through a small configuration port. They reset to empty, so after boot only the low exception-vector area, ROM and the peripherals respond.

Top module: `bus_addr_decoder`

## Requirements
- R1: During and right after reset, `resp_valid`, every select, `bus_error` and `lanes` are 0, and the boot overlay is armed.
- R2: While the overlay is armed, a read with size code 2 (4 bytes) at address 0x000000 or 0x000004 selects ROM, and its offset equals the address. The overlay disarms after the read at 0x000004.
- R3: While the overlay is armed, any access other than those two reads gives `bus_error`.
- R4: ROM spans 0x100000 to 0x10FFFF. A read there selects ROM, and the offset is the address minus 0x100000.
- R5: Size code 0 means 1 byte, code 1 means 2 bytes and code 2 means 4 bytes. Code 3 always gives `bus_error`. An N-byte access hits a memory range only if start <= addr and addr + N <= end.
- R6: The window 0x180000 to 0x1FFFFF drives `sel_periph[0]`, and the window 0x200000 to 0x27FFFF drives `sel_periph[1]`. In both, the offset is the address minus the window base.
- R7: Eight windows of 0x4000 bytes, with bases 0x3A0001 + k*0x4000 for k = 0 to 7, drive `sel_periph[2+k]`. The base is inclusive and the end exclusive. The offset is (address - base) shifted right by one.
- R8: A write that lands in ROM or in the read-only RAM window gives `bus_error`. Writes are accepted in the read-write window, in the peripherals and in the vector area.
- R9: `cfg_idx` selects a bound: 0 is read-only start, 1 is read-only end, 2 is read-write start and 3 is read-write end. All four reset to 0, so both windows are empty. A write takes effect on the next access. The read-only window is checked before the read-write window, and a window hit selects RAM with offset equal to the address.
- R10: An access that no other region claims and that satisfies addr + N <= 0x400 selects RAM, with offset equal to the address.
- R11: An access that no region claims gives a one-cycle `bus_error`, with no select and `lanes` = 0.
- R12: `lanes[3]` is the most significant byte, the one at addr[1:0] = 0. The mask is 4'b1000, 4'b1100 or 4'b1111 for 1, 2 or 4 bytes, shifted right by addr[1:0].
- R13: Results appear exactly one cycle after `req_valid`, together with a one-cycle `resp_valid`. Without a strobe, nothing is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | Size code (0: 1 B, 1: 2 B, 2: 4 B, 3: reserved) |
| req_write | input | 1 | 1 for write, 0 for read |
| cfg_we | input | 1 | Write strobe for a window bound |
| cfg_idx | input | 2 | Which bound to write |
| cfg_wdata | input | 24 | Bound value |
| resp_valid | output | 1 | Result valid, one cycle after the strobe |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_periph | output | 10 | Peripheral window selects |
| local_off | output | 24 | Offset inside the selected target |
| lanes | output | 4 | Active byte lanes, bit 3 most significant |
| bus_error | output | 1 | Invalid access pulse |

## Verification
The bench builds the decoder with its default parameters: two wide even-based windows, eight narrow odd-based windows, a 1 MiB RAM, a 64 KiB ROM and a 1 KiB vector area. These values place every region edge at a concrete address. The bench can therefore probe the last legal long word of ROM, the first address past each peripheral window, and the even address just below an odd window base. It can also reach the halved offset at the top of a narrow window and the off-by-N fit failures at the end of the vector area and of the programmed windows.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int ADDR_W = 24;
    localparam int LANE_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              ram;
        logic              rom;
        logic              err;
        logic [ADDR_W-1:0] off;
    } dec_res_t;

    function automatic logic [ADDR_W:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = (ADDR_W+1)'(1);
            SZ_WORD: size_bytes = (ADDR_W+1)'(2);
            SZ_LONG: size_bytes = (ADDR_W+1)'(4);
            default: size_bytes = '0;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] lane_mask(input logic [1:0] sz,
                                                   input logic [1:0] lo);
        logic [LANE_W-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b1000;
            SZ_WORD: m = 4'b1100;
            SZ_LONG: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        lane_mask = m >> lo;
    endfunction

    function automatic logic fits(input logic [ADDR_W:0] a,
                                  input logic [ADDR_W:0] n,
                                  input logic [ADDR_W:0] lo,
                                  input logic [ADDR_W:0] hi);
        fits = (a >= lo) && ((a + n) <= hi);
    endfunction

endpackage

// File: rtl/ad_window_regs.sv
module ad_window_regs
    import addr_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] ro_lo,
    output logic [ADDR_W-1:0] ro_hi,
    output logic [ADDR_W-1:0] rw_lo,
    output logic [ADDR_W-1:0] rw_hi
);
    logic [ADDR_W-1:0] bound_q [4];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) bound_q[i] <= '0;
        end else if (cfg_we) begin
            bound_q[cfg_idx] <= cfg_wdata;
        end
    end

    assign ro_lo = bound_q[0];
    assign ro_hi = bound_q[1];
    assign rw_lo = bound_q[2];
    assign rw_hi = bound_q[3];

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(ro_lo) && $stable(ro_hi) && $stable(rw_lo) && $stable(rw_hi)) // R9
        else $error("window bound changed without a write");
endmodule

// File: rtl/ad_boot_overlay.sv
module ad_boot_overlay
    import addr_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    output logic              boot_active,
    output logic              boot_hit
);
    logic armed_q;

    assign boot_hit = armed_q && !req_write && (req_size == SZ_LONG) &&
                      ((req_addr == ADDR_W'(0)) || (req_addr == ADDR_W'(4)));

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b1;
        else if (req_valid && boot_hit && req_addr[2])
            armed_q <= 1'b0;
    end

    assign boot_active = armed_q;

    AST_BOOT_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(boot_active) |-> $past(req_valid && !req_write &&
                                     req_size == SZ_LONG && req_addr == ADDR_W'(4))) // R2
        else $error("boot overlay left without the second vector fetch");
endmodule

// File: rtl/ad_periph_match.sv
module ad_periph_match
    import addr_dec_pkg::*;
#(
    parameter int unsigned N_WIDE      = 2,
    parameter int unsigned WIDE_BASE   = 32'h18_0000,
    parameter int unsigned WIDE_SPAN   = 32'h8_0000,
    parameter int unsigned N_NARROW    = 8,
    parameter int unsigned NARROW_BASE = 32'h3A_0001,
    parameter int unsigned NARROW_SPAN = 32'h4000,
    localparam int         N_WIN       = N_WIDE + N_NARROW
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_WIN-1:0]  hit,
    output logic [ADDR_W-1:0] off
);
    logic [N_WIN-1:0]  raw;
    logic [ADDR_W-1:0] offs [N_WIN];

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        localparam int unsigned BASE_I = (g < N_WIDE) ? WIDE_BASE + g * WIDE_SPAN
                                       : NARROW_BASE + (g - N_WIDE) * NARROW_SPAN;
        localparam int unsigned SPAN_I = (g < N_WIDE) ? WIDE_SPAN : NARROW_SPAN;
        localparam int unsigned END_I  = BASE_I + SPAN_I;
        localparam logic [ADDR_W:0] BASE = BASE_I[ADDR_W:0];
        localparam logic [ADDR_W:0] ENDX = END_I[ADDR_W:0];
        logic [ADDR_W-1:0] diff;
        assign raw[g] = ({1'b0, addr} >= BASE) && ({1'b0, addr} < ENDX);
        assign diff   = addr - BASE[ADDR_W-1:0];
        if (BASE_I[0]) begin : g_odd
            assign offs[g] = diff >> 1;
        end else begin : g_even
            assign offs[g] = diff;
        end
    end

    always_comb begin
        hit = '0;
        off = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (raw[i]) begin
                hit = '0;
                hit[i] = 1'b1;
                off = offs[i];
            end
        end
    end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int unsigned RAM_BASE    = 32'h00_0000,
    parameter int unsigned ROM_BASE    = 32'h10_0000,
    parameter int unsigned ROM_BYTES   = 32'h1_0000,
    parameter int unsigned VEC_BYTES   = 32'h400,
    parameter int unsigned N_WIDE      = 2,
    parameter int unsigned WIDE_BASE   = 32'h18_0000,
    parameter int unsigned WIDE_SPAN   = 32'h8_0000,
    parameter int unsigned N_NARROW    = 8,
    parameter int unsigned NARROW_BASE = 32'h3A_0001,
    parameter int unsigned NARROW_SPAN = 32'h4000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [23:0]                req_addr,
    input  logic [1:0]                 req_size,
    input  logic                       req_write,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_idx,
    input  logic [23:0]                cfg_wdata,
    output logic                       resp_valid,
    output logic                       sel_ram,
    output logic                       sel_rom,
    output logic [N_WIDE+N_NARROW-1:0] sel_periph,
    output logic [23:0]                local_off,
    output logic [3:0]                 lanes,
    output logic                       bus_error
);
    localparam int              N_WIN  = N_WIDE + N_NARROW;
    localparam int unsigned     ROM_END_I = ROM_BASE + ROM_BYTES;
    localparam logic [ADDR_W:0] ROM_LO = ROM_BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] ROM_HI = ROM_END_I[ADDR_W:0];
    localparam logic [ADDR_W:0] VEC_HI = VEC_BYTES[ADDR_W:0];

    logic [ADDR_W-1:0] ro_lo, ro_hi, rw_lo, rw_hi;
    logic              boot_active, boot_hit;
    logic [N_WIN-1:0]  per_hit;
    logic [ADDR_W-1:0] per_off;
    logic [ADDR_W:0]   a_x, n_x;
    dec_res_t          res;
    logic [N_WIN-1:0]  res_per;

    ad_window_regs i_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .ro_lo(ro_lo), .ro_hi(ro_hi), .rw_lo(rw_lo), .rw_hi(rw_hi)
    );

    ad_boot_overlay i_boot (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write),
        .boot_active(boot_active), .boot_hit(boot_hit)
    );

    ad_periph_match #(
        .N_WIDE(N_WIDE), .WIDE_BASE(WIDE_BASE), .WIDE_SPAN(WIDE_SPAN),
        .N_NARROW(N_NARROW), .NARROW_BASE(NARROW_BASE), .NARROW_SPAN(NARROW_SPAN)
    ) i_periph (
        .addr(req_addr), .hit(per_hit), .off(per_off)
    );

    assign a_x = {1'b0, req_addr};
    assign n_x = size_bytes(req_size);

    always_comb begin
        res     = '0;
        res_per = '0;
        if (req_size == SZ_RSVD) begin
            res.err = 1'b1;
        end else if (boot_active) begin
            if (boot_hit) begin
                res.rom = 1'b1;
                res.off = req_addr;
            end else begin
                res.err = 1'b1;
            end
        end else if (fits(a_x, n_x, {1'b0, ro_lo}, {1'b0, ro_hi})) begin
            res.err = req_write;
            res.ram = !req_write;
            res.off = req_addr - RAM_BASE[ADDR_W-1:0];
        end else if (fits(a_x, n_x, {1'b0, rw_lo}, {1'b0, rw_hi})) begin
            res.ram = 1'b1;
            res.off = req_addr - RAM_BASE[ADDR_W-1:0];
        end else if (fits(a_x, n_x, ROM_LO, ROM_HI)) begin
            res.err = req_write;
            res.rom = !req_write;
            res.off = req_addr - ROM_BASE[ADDR_W-1:0];
        end else if (|per_hit) begin
            res_per = per_hit;
            res.off = per_off;
        end else if ((a_x + n_x) <= VEC_HI) begin
            res.ram = 1'b1;
            res.off = req_addr;
        end else begin
            res.err = 1'b1;
        end
        if (res.err) res.off = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            resp_valid <= 1'b0;
            sel_ram    <= 1'b0;
            sel_rom    <= 1'b0;
            sel_periph <= '0;
            local_off  <= '0;
            lanes      <= '0;
            bus_error  <= 1'b0;
        end else begin
            resp_valid <= 1'b1;
            sel_ram    <= res.ram;
            sel_rom    <= res.rom;
            sel_periph <= res_per;
            local_off  <= res.off;
            lanes      <= res.err ? 4'b0000 : lane_mask(req_size, req_addr[1:0]);
            bus_error  <= res.err;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_ram, sel_rom, sel_periph, bus_error})) // R11
        else $error("more than one select or error at once");

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_error |-> (lanes == 4'b0000) && resp_valid) // R11
        else $error("error with lanes active");

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid && !bus_error && !sel_ram && !sel_rom) // R13
        else $error("result without a strobe");

    AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        sel_rom |-> !$past(req_write)) // R8
        else $error("ROM selected for a write");

    AST_BOOT_ONLY_ROM: assert property (@(posedge clk) disable iff (rst)
        req_valid && boot_active |=> bus_error || (sel_rom && (local_off == 24'd0 || local_off == 24'd4))) // R3
        else $error("access during boot not steered to ROM vectors");
endmodule

// File: tb/test_bus_addr_decoder.sv
module test_bus_addr_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic        ram;
        logic        rom;
        logic [9:0]  per;
        logic [23:0] off;
        logic [3:0]  lanes;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [23:0] cfg_wdata = '0;
    logic        resp_valid, sel_ram, sel_rom, bus_error;
    logic [9:0]  sel_periph;
    logic [23:0] local_off;
    logic [3:0]  lanes;

    int   errors = 0;
    int   checks = 0;
    exp_t exp_q[$];
    bit   done = 1'b0;

    bus_addr_decoder i_bus_addr_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .resp_valid(resp_valid),
        .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_periph(sel_periph),
        .local_off(local_off), .lanes(lanes), .bus_error(bus_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic acc(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                       input logic e_ram, input logic e_rom, input logic [9:0] e_per,
                       input logic [23:0] e_off, input logic [3:0] e_lanes,
                       input logic e_err, input string tag);
        exp_t e;
        e.ram = e_ram; e.rom = e_rom; e.per = e_per; e.off = e_off;
        e.lanes = e_lanes; e.err = e_err; e.tag = tag;
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        exp_q.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic err_acc(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                           input string tag);
        acc(a, sz, wr, 0, 0, 10'h0, 24'h0, 4'h0, 1, tag);
    endtask

    task automatic cfg(input logic [1:0] idx, input logic [23:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R13: response with no access pending (actual resp_valid=1, expected 0)");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (sel_ram !== e.ram || sel_rom !== e.rom || sel_periph !== e.per ||
                    local_off !== e.off || lanes !== e.lanes || bus_error !== e.err) begin
                    errors++;
                    $display("FAIL %s: actual ram=%b rom=%b per=%h off=%h lanes=%b err=%b expected ram=%b rom=%b per=%h off=%h lanes=%b err=%b",
                             e.tag, sel_ram, sel_rom, sel_periph, local_off, lanes, bus_error,
                             e.ram, e.rom, e.per, e.off, e.lanes, e.err);
                end
            end
        end else if (!rst && (bus_error || sel_ram || sel_rom || sel_periph != 0)) begin
            checks++; errors++;
            $display("FAIL R13: outputs active without resp_valid (actual err=%b, expected 0)", bus_error);
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung (actual cycles=%0d, expected fewer)", WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (resp_valid !== 0 || sel_ram !== 0 || sel_rom !== 0 || sel_periph !== 0 ||
            bus_error !== 0 || lanes !== 0) begin
            errors++;
            $display("FAIL R1: outputs during reset (actual valid=%b err=%b, expected 0)", resp_valid, bus_error);
        end
        #1 rst = 1'b0;

        // R3: boot overlay armed after reset (R1), rejects anything else
        err_acc(24'h000010, 2'd0, 0, "R3 byte read in boot");
        err_acc(24'h100000, 2'd2, 0, "R3 rom read in boot");
        // R2: vector fetches go to ROM
        acc(24'h000000, 2'd2, 0, 0, 1, 10'h0, 24'h000000, 4'b1111, 0, "R2 vector 0");
        acc(24'h000004, 2'd2, 0, 0, 1, 10'h0, 24'h000004, 4'b1111, 0, "R2 vector 4");
        // R10 vector area after overlay ends
        acc(24'h000000, 2'd2, 0, 1, 0, 10'h0, 24'h000000, 4'b1111, 0, "R10 vector area long");
        acc(24'h0003FF, 2'd0, 1, 1, 0, 10'h0, 24'h0003FF, 4'b0001, 0, "R10 vector last byte write");
        err_acc(24'h0003FF, 2'd1, 0, "R5 word past vector area");
        // R4 ROM
        acc(24'h10FFFC, 2'd2, 0, 0, 1, 10'h0, 24'h00FFFC, 4'b1111, 0, "R4 last rom long");
        err_acc(24'h10FFFD, 2'd2, 0, "R5 long overrunning rom");
        err_acc(24'h100000, 2'd1, 1, "R8 rom write");
        err_acc(24'h100000, 2'd3, 0, "R5 reserved size");
        // R6 wide windows
        acc(24'h180010, 2'd1, 0, 0, 0, 10'h001, 24'h000010, 4'b1100, 0, "R6 wide window 0");
        acc(24'h27FFFF, 2'd0, 1, 0, 0, 10'h002, 24'h07FFFF, 4'b0001, 0, "R6 wide window 1 top");
        err_acc(24'h280000, 2'd0, 0, "R11 past wide window");
        // R7 narrow windows
        acc(24'h3A0001, 2'd0, 0, 0, 0, 10'h004, 24'h000000, 4'b0100, 0, "R7 narrow 0 base");
        acc(24'h3A4000, 2'd0, 1, 0, 0, 10'h004, 24'h001FFF, 4'b1000, 0, "R7 narrow 0 top");
        acc(24'h3A4001, 2'd0, 0, 0, 0, 10'h008, 24'h000000, 4'b0100, 0, "R7 narrow 1 base");
        acc(24'h3BC007, 2'd1, 0, 0, 0, 10'h200, 24'h000003, 4'b0001, 0, "R7 narrow 7 halved");
        err_acc(24'h3C0001, 2'd0, 0, "R7 end exclusive");
        err_acc(24'h3A0000, 2'd0, 0, "R11 below odd base");
        // R9 windows empty after reset
        err_acc(24'h001000, 2'd2, 0, "R9 empty window");
        cfg(2'd0, 24'h001000);
        cfg(2'd1, 24'h002000);
        cfg(2'd2, 24'h004000);
        cfg(2'd3, 24'h005000);
        acc(24'h001FFC, 2'd2, 0, 1, 0, 10'h0, 24'h001FFC, 4'b1111, 0, "R9 ro window read");
        err_acc(24'h001000, 2'd0, 1, "R8 ro window write");
        err_acc(24'h001FFD, 2'd2, 0, "R5 ro window overrun");
        acc(24'h004FFC, 2'd2, 1, 1, 0, 10'h0, 24'h004FFC, 4'b1111, 0, "R8 rw window write");
        err_acc(24'h005000, 2'd0, 0, "R9 rw end exclusive");
        acc(24'h004002, 2'd1, 0, 1, 0, 10'h0, 24'h004002, 4'b0011, 0, "R12 word lanes");
        acc(24'h004001, 2'd0, 1, 1, 0, 10'h0, 24'h004001, 4'b0100, 0, "R12 byte lanes");
        // R13: idle cycles produce nothing (monitor flags stray output)
        repeat (4) @(posedge clk);
        // R1: reset rearms overlay and clears windows
        do_reset();
        acc(24'h000000, 2'd2, 0, 0, 1, 10'h0, 24'h000000, 4'b1111, 0, "R1 overlay rearmed");
        err_acc(24'h001FFC, 2'd1, 0, "R3 word during rearmed boot");
        acc(24'h000004, 2'd2, 0, 0, 1, 10'h0, 24'h000004, 4'b1111, 0, "R2 second vector");
        err_acc(24'h001FFC, 2'd2, 0, "R9 windows cleared by reset");

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R13: missing responses (actual pending=%0d, expected 0)", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule